// File: doc/BRIEF.md
# Double-Buffered Frame Select Controller

This block steers a display subsystem that owns two frame buffers. One buffer is scanned out while the drawing processor fills the other. The block holds a display mode register and a frame-select register behind a small byte/word register port. It owns the "which buffer is on screen" state and turns drawing writes into per-buffer write enables that always hit the hidden buffer.

A request to show the other buffer takes effect at once when the display is blanked or switched off. At any other time the request is parked and applied at the start of the next vertical blank, so the picture never tears mid-frame. A change of the priority bit in the mode register raises a one-cycle palette-dirty strobe. The palette logic downstream uses it to rebuild its inverted-priority colours.

The register window is 16 bytes wide. Byte offset 1 holds the low byte of the mode register and byte offset 0xB holds the frame-select bit. Word offset 0xA reads back status.

Top module: `fsc_frame_select`

## Requirements
- R1: After reset, show_sel is 0, draw_sel is 1, the mode register reads 0 in bits 7:0, and pal_dirty is 0.
- R2: A write to byte offset 0xB whose bit 0 differs from show_sel changes show_sel to that bit at the next clock edge when vblank_in is 1 or the mode field (mode bits 1:0) is 0.
- R3: A write to byte offset 0xB made while vblank_in is 0 and the mode field is nonzero leaves show_sel unchanged and records the requested bit as pending. A later such write replaces the pending bit.
- R4: At the first clock edge where vblank_in is sampled 1 after being sampled 0, show_sel takes the pending bit.
- R5: draw_sel is always the inverse of show_sel. A drawing write inside the window raises exactly fb_we[draw_sel] in the same cycle and never fb_we[show_sel].
- R6: A drawing write whose address bits 15:12 differ from 4'h4, or a cycle without draw_wr_en, raises no fb_we bit. fb_addr is draw_addr bits 11:0.
- R7: A 16-bit register write (reg_wr_word=1) to an even offset acts as a byte write of data bits 7:0 to the next odd offset. A byte write to offset 0 or offset 0xA changes nothing.
- R8: A write to the mode register replaces mode bits 7:0. Read offset 0 returns the mode byte in bits 7:0 and pal_ind_in in bit 15, and no write can change bit 15.
- R9: pal_dirty is 1 for exactly the cycle after a mode write that toggles mode bit 7. It is 0 after a mode write that leaves bit 7 unchanged.
- R10: Read offset 0xA returns show_sel in bit 0 and vblank_in in bit 15, with all other bits 0. Reads are combinational from reg_rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| reg_wr_addr | input | 4 | Register byte offset |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 4 | Register read offset (bit 0 ignored) |
| reg_rd_data | output | 16 | Register read data |
| vblank_in | input | 1 | Vertical blank flag |
| pal_ind_in | input | 1 | Read-only video standard indication |
| draw_wr_en | input | 1 | Drawing write strobe |
| draw_addr | input | 16 | Drawing write word address |
| draw_wdata | input | 16 | Drawing write data |
| fb_we | output | 2 | Per-buffer write enable |
| fb_addr | output | 12 | Buffer word address |
| fb_wdata | output | 16 | Buffer write data |
| show_sel | output | 1 | Displayed buffer index |
| draw_sel | output | 1 | Buffer that drawing writes target |
| pal_dirty | output | 1 | Palette rebuild strobe |

## Verification
Register writes and vertical-blank edges move show_sel, draw_sel and the mode register one clock edge after the input is presented. The bench therefore drives each stimulus on a falling edge and checks these results on the following falling edge. pal_dirty is due in that same half-cycle window and must be gone one cycle later, so it is sampled at both points. fb_we, fb_addr and reg_rd_data are combinational. They are checked a nanosecond after their inputs change, without any clock edge in between.

// File: rtl/fsc_pkg.sv
// Package: shared offsets, bit positions and the normalized register byte op
// used by the frame select controller. Assumes a 16-byte register window.
package fsc_pkg;
    localparam int REG_AW      = 4;
    localparam int REG_DW      = 16;
    localparam int BYTE_W      = 8;
    localparam int MODE_FLD_W  = 2;
    localparam int PRIO_BIT    = 7;
    localparam int PALIND_BIT  = 15;
    localparam int VBLANK_BIT  = 15;

    localparam logic [REG_AW-1:0] OFS_MODE_LO  = 4'h1;
    localparam logic [REG_AW-1:0] OFS_MODE_RD  = 4'h0;
    localparam logic [REG_AW-1:0] OFS_FRAME_LO = 4'hB;
    localparam logic [REG_AW-1:0] OFS_STATUS   = 4'hA;

    typedef struct packed {
        logic              valid;
        logic [REG_AW-1:0] addr;
        logic [BYTE_W-1:0] data;
    } byte_op_t;
endpackage

// File: rtl/fsc_reg_decode.sv
// Module: fsc_reg_decode
// Turns a byte or word register write into a single byte operation and
// decodes it into per-register strobes. A word write is folded onto its odd
// byte (low data byte), which is the only byte the registers implement.
// Assumes: purely combinational, one write per cycle.
module fsc_reg_decode
    import fsc_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output byte_op_t          op,
    output logic              mode_we,
    output logic              frame_we
);
    // Normalize the access width onto one byte op.
    always_comb begin
        op.valid = wr_en;
        op.addr  = wr_word ? {wr_addr[REG_AW-1:1], 1'b1} : wr_addr;
        op.data  = wr_data[BYTE_W-1:0];
    end

    // Decode the byte op into register strobes.
    always_comb begin
        mode_we  = op.valid && (op.addr == OFS_MODE_LO);
        frame_we = op.valid && (op.addr == OFS_FRAME_LO);
    end
endmodule

// File: rtl/fsc_mode_reg.sv
// Module: fsc_mode_reg
// Holds the writable low byte of the display mode register and raises a
// one-cycle palette-dirty strobe when a write flips the priority bit.
// Assumes: mode_we is a single-cycle strobe from fsc_reg_decode.
module fsc_mode_reg
    import fsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_we,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     mode_lo,
    output logic [MODE_FLD_W-1:0] mode_field,
    output logic                  pal_dirty
);
    logic [BYTE_W-1:0] mode_q;
    logic              dirty_q;

    // Store the mode byte and flag a priority-bit change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dirty_q <= 1'b0;
        end else begin
            dirty_q <= 1'b0;
            if (mode_we) begin
                mode_q  <= wdata;
                dirty_q <= wdata[PRIO_BIT] ^ mode_q[PRIO_BIT];
            end
        end
    end

    // Expose the register fields.
    always_comb begin
        mode_lo    = mode_q;
        mode_field = mode_q[MODE_FLD_W-1:0];
        pal_dirty  = dirty_q;
    end
endmodule

// File: rtl/fsc_frame_ctrl.sv
// Module: fsc_frame_ctrl
// Owns the displayed-buffer bit. A request applies at once while blanked or
// with the display off, otherwise it waits for the next vertical-blank rise.
// Assumes: vblank_in is synchronous to clk.
module fsc_frame_ctrl
    import fsc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_we,
    input  logic                  req_bit,
    input  logic                  vblank_in,
    input  logic [MODE_FLD_W-1:0] mode_field,
    output logic                  show_sel,
    output logic                  pend_bit
);
    logic fs_q;
    logic pend_q;
    logic vb_q;
    logic vb_rise;
    logic swap_now;

    // Decide whether a swap can be taken this cycle.
    always_comb begin
        vb_rise  = vblank_in && !vb_q;
        swap_now = vblank_in || (mode_field == '0);
    end

    // Update the displayed bit, the pending request and the blank history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= 1'b0;
            pend_q <= 1'b0;
            vb_q   <= 1'b0;
        end else begin
            vb_q <= vblank_in;
            if (frame_we) begin
                pend_q <= req_bit;
                if (swap_now && (req_bit != fs_q))
                    fs_q <= req_bit;
            end else if (vb_rise && (pend_q != fs_q)) begin
                fs_q <= pend_q;
            end
        end
    end

    // Drive the outputs from state.
    always_comb begin
        show_sel = fs_q;
        pend_bit = pend_q;
    end
endmodule

// File: rtl/fsc_draw_route.sv
// Module: fsc_draw_route
// Decodes drawing writes that fall in the frame buffer window and raises the
// write enable of the hidden buffer only. Combinational, zero latency.
// Assumes: NBUF buffers indexed by draw_sel.
module fsc_draw_route #(
    parameter int BUS_AW = 16,
    parameter int FB_AW  = 12,
    parameter int DW     = 16,
    parameter int NBUF   = 2,
    parameter logic [BUS_AW-FB_AW-1:0] WIN_TAG = 4'h4
) (
    input  logic                     draw_wr_en,
    input  logic [BUS_AW-1:0]        draw_addr,
    input  logic [DW-1:0]            draw_wdata,
    input  logic [$clog2(NBUF)-1:0]  draw_sel,
    output logic [NBUF-1:0]          fb_we,
    output logic [FB_AW-1:0]         fb_addr,
    output logic [DW-1:0]            fb_wdata
);
    logic hit;

    // Window decode on the upper address bits.
    always_comb hit = draw_wr_en && (draw_addr[BUS_AW-1:FB_AW] == WIN_TAG);

    // One enable per buffer.
    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        always_comb fb_we[g] = hit && (draw_sel == g[$clog2(NBUF)-1:0]);
    end

    // Pass address and data through.
    always_comb begin
        fb_addr  = draw_addr[FB_AW-1:0];
        fb_wdata = draw_wdata;
    end
endmodule

// File: rtl/fsc_frame_select.sv
// Module: fsc_frame_select (top)
// Double-buffered frame select controller: register port, mode register,
// frame swap control and hidden-buffer write routing.
// Assumes: single clock, synchronous active-low reset, combinational reads.
module fsc_frame_select
    import fsc_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int FB_AW  = 12,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_word,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [REG_DW-1:0] reg_wr_data,
    input  logic [REG_AW-1:0] reg_rd_addr,
    output logic [REG_DW-1:0] reg_rd_data,
    input  logic              vblank_in,
    input  logic              pal_ind_in,
    input  logic              draw_wr_en,
    input  logic [BUS_AW-1:0] draw_addr,
    input  logic [DW-1:0]     draw_wdata,
    output logic [1:0]        fb_we,
    output logic [FB_AW-1:0]  fb_addr,
    output logic [DW-1:0]     fb_wdata,
    output logic              show_sel,
    output logic              draw_sel,
    output logic              pal_dirty
);
    localparam int NBUF = 2;

    byte_op_t              op;
    logic                  mode_we;
    logic                  frame_we;
    logic [BYTE_W-1:0]     mode_lo;
    logic [MODE_FLD_W-1:0] mode_field;
    logic                  pend_bit;

    fsc_reg_decode u_dec (
        .wr_en    (reg_wr_en),
        .wr_word  (reg_wr_word),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .op       (op),
        .mode_we  (mode_we),
        .frame_we (frame_we)
    );

    fsc_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .wdata      (op.data),
        .mode_lo    (mode_lo),
        .mode_field (mode_field),
        .pal_dirty  (pal_dirty)
    );

    fsc_frame_ctrl u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_we   (frame_we),
        .req_bit    (op.data[0]),
        .vblank_in  (vblank_in),
        .mode_field (mode_field),
        .show_sel   (show_sel),
        .pend_bit   (pend_bit)
    );

    // The drawing side always targets the buffer not on screen.
    always_comb draw_sel = ~show_sel;

    fsc_draw_route #(
        .BUS_AW (BUS_AW),
        .FB_AW  (FB_AW),
        .DW     (DW),
        .NBUF   (NBUF)
    ) u_route (
        .draw_wr_en (draw_wr_en),
        .draw_addr  (draw_addr),
        .draw_wdata (draw_wdata),
        .draw_sel   (draw_sel),
        .fb_we      (fb_we),
        .fb_addr    (fb_addr),
        .fb_wdata   (fb_wdata)
    );

    // Read mux over word offsets.
    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_addr[REG_AW-1:1] == OFS_MODE_RD[REG_AW-1:1]) begin
            reg_rd_data[BYTE_W-1:0] = mode_lo;
            reg_rd_data[PALIND_BIT] = pal_ind_in;
        end else if (reg_rd_addr[REG_AW-1:1] == OFS_STATUS[REG_AW-1:1]) begin
            reg_rd_data[0]          = show_sel;
            reg_rd_data[VBLANK_BIT] = vblank_in;
        end
    end
endmodule

// File: rtl/fsc_frame_select_chk.sv
// Module: fsc_frame_select_chk
// Property checker bound to fsc_frame_select.
module fsc_frame_select_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        vblank_in,
    input logic        pal_ind_in,
    input logic        draw_wr_en,
    input logic [3:0]  reg_rd_addr,
    input logic [15:0] reg_rd_data,
    input logic [1:0]  mode_field,
    input logic [1:0]  fb_we,
    input logic        show_sel,
    input logic        pal_dirty
);
    assert_swap_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(show_sel) |-> ($past(vblank_in) || vblank_in || $past(mode_field) == 2'd0));

    assert_we_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fb_we));

    assert_shown_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we[show_sel] == 1'b0);

    assert_no_we_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !draw_wr_en |-> (fb_we == 2'b00));

    assert_dirty_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pal_dirty |-> $past(reg_wr_en));

    assert_palbit_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_addr[3:1] == 3'd0) |-> (reg_rd_data[15] == pal_ind_in));
endmodule

bind fsc_frame_select fsc_frame_select_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .vblank_in   (vblank_in),
    .pal_ind_in  (pal_ind_in),
    .draw_wr_en  (draw_wr_en),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data),
    .mode_field  (mode_field),
    .fb_we       (fb_we),
    .show_sel    (show_sel),
    .pal_dirty   (pal_dirty)
);

// File: tb/fsc_frame_select_tb_top.sv
`timescale 1ns/1ps
module fsc_frame_select_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_word = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [15:0] reg_rd_data;
    logic        vblank_in = 1'b0;
    logic        pal_ind_in = 1'b0;
    logic        draw_wr_en = 1'b0;
    logic [15:0] draw_addr = '0;
    logic [15:0] draw_wdata = '0;
    logic [1:0]  fb_we;
    logic [11:0] fb_addr;
    logic [15:0] fb_wdata;
    logic        show_sel;
    logic        draw_sel;
    logic        pal_dirty;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fsc_frame_select dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input bit word);
        reg_wr_en = 1'b1; reg_wr_word = word; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string req);
        reg_rd_addr = a;
        #1;
        chk(reg_rd_data == exp, req, reg_rd_data, exp);
    endtask

    task automatic set_vb(input bit v);
        vblank_in = v;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(show_sel == 1'b0, "R1 show_sel", show_sel, 0);
        chk(draw_sel == 1'b1, "R1 draw_sel", draw_sel, 1);
        chk(pal_dirty == 1'b0, "R1 pal_dirty", pal_dirty, 0);
        rd_chk(4'h0, 16'h0000, "R1 mode");

        // R2/R3/R4 sweep over mode, blank, start and request
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 2; v++) begin
                for (int f0 = 0; f0 < 2; f0++) begin
                    for (int r = 0; r < 2; r++) begin
                        int exp_fs;
                        set_vb(1'b0);
                        wr(4'h1, 16'h0000, 1'b0);
                        wr(4'hB, 16'(f0), 1'b0);
                        chk(show_sel == f0[0], "R2 setup", show_sel, f0);
                        wr(4'h1, 16'(m), 1'b0);
                        set_vb(v[0]);
                        set_vb(v[0]);
                        wr(4'hB, 16'(r), 1'b0);
                        exp_fs = (v == 1 || m == 0) ? r : f0;
                        chk(show_sel == exp_fs[0],
                            (exp_fs == r) ? "R2 immediate swap" : "R3 held swap", show_sel, exp_fs);
                        chk(draw_sel == !exp_fs[0], "R5 draw_sel inverse", draw_sel, !exp_fs[0]);
                        rd_chk(4'hA, {v[0], 14'd0, exp_fs[0]}, "R10 status");
                        if (v == 0) begin
                            set_vb(1'b1);
                            chk(show_sel == r[0], "R4 apply at blank rise", show_sel, r);
                            set_vb(1'b0);
                        end
                    end
                end
            end
        end

        // R3 later write replaces pending
        set_vb(1'b0);
        wr(4'h1, 16'h0000, 1'b0);
        wr(4'hB, 16'h0000, 1'b0);
        wr(4'h1, 16'h0003, 1'b0);
        wr(4'hB, 16'h0001, 1'b0);
        wr(4'hB, 16'h0000, 1'b0);
        set_vb(1'b1);
        chk(show_sel == 1'b0, "R3 pending replaced", show_sel, 0);
        set_vb(1'b0);

        // R7 word write folds onto odd byte; even byte writes ignored
        wr(4'hA, 16'hFF01, 1'b1);
        set_vb(1'b1);
        chk(show_sel == 1'b1, "R7 word write to frame", show_sel, 1);
        set_vb(1'b0);
        wr(4'h1, 16'h0000, 1'b0);
        wr(4'hA, 16'h0000, 1'b0);
        chk(show_sel == 1'b1, "R7 byte to even frame offset ignored", show_sel, 1);
        wr(4'h0, 16'h00C2, 1'b1);
        rd_chk(4'h0, 16'h00C2, "R7 word write to mode");
        wr(4'h0, 16'h0055, 1'b0);
        rd_chk(4'h0, 16'h00C2, "R7 byte to even mode offset ignored");

        // R8 read-only indication bit
        pal_ind_in = 1'b1;
        wr(4'h0, 16'h0011, 1'b1);
        rd_chk(4'h0, 16'h8011, "R8 mode with indication");
        pal_ind_in = 1'b0;
        wr(4'h0, 16'hFF22, 1'b1);
        rd_chk(4'h0, 16'h0022, "R8 indication not writable");

        // R9 palette dirty on priority toggle
        wr(4'h1, 16'h00A2, 1'b0);
        chk(pal_dirty == 1'b1, "R9 dirty on toggle", pal_dirty, 1);
        @(negedge clk);
        chk(pal_dirty == 1'b0, "R9 one cycle", pal_dirty, 0);
        wr(4'h1, 16'h0083, 1'b0);
        chk(pal_dirty == 1'b0, "R9 no toggle no dirty", pal_dirty, 0);
        wr(4'h1, 16'h0003, 1'b0);
        chk(pal_dirty == 1'b1, "R9 dirty on clear", pal_dirty, 1);
        @(negedge clk);

        // R5/R6 routing sweep over shown buffer and address tag
        for (int s = 0; s < 2; s++) begin
            wr(4'h1, 16'h0000, 1'b0);
            wr(4'hB, 16'(s), 1'b0);
            for (int tag = 0; tag < 16; tag++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [1:0] exp_we;
                    draw_wr_en = en[0];
                    draw_addr  = {tag[3:0], 12'h5A3 + 12'(tag)};
                    draw_wdata = 16'h1234 ^ 16'(tag);
                    #1;
                    exp_we = (en == 1 && tag == 4) ? (s == 0 ? 2'b10 : 2'b01) : 2'b00;
                    chk(fb_we == exp_we, (tag == 4) ? "R5 hidden buffer enable" : "R6 no enable",
                        fb_we, exp_we);
                    chk(fb_addr == 12'h5A3 + 12'(tag) && fb_wdata == (16'h1234 ^ 16'(tag)),
                        "R6 address and data", fb_addr, 12'h5A3 + 12'(tag));
                end
            end
            draw_wr_en = 1'b0;
            @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule